// File: doc/BRIEF.md
# Three-Wire Synthesizer Setup Port

This block receives configuration for a frequency synthesizer over three slow wires: a serial clock, a serial data line and a load strobe. All three are brought into the system clock through two-flop synchronizers, and edges are found in the system domain. Each rising serial-clock edge moves one data bit into a 19-bit shift register, most significant bit first, while the load strobe is low.

A rising edge on the load strobe copies the shift register into one of two holding registers. The last bit shifted in (bit 0) is a routing flag. When it is 1, the word goes to the reference register: a 14-bit reference divide ratio and four single-bit options. When it is 0, the word goes to the divider register: a 7-bit swallow count and an 11-bit main count. A word whose reference ratio or main count is below 3 is refused. The target register keeps its old contents, and a sticky error flag is raised.

The holding registers drive the outputs directly, in the system clock domain.

Top module: `synth_cfg_port`

## Requirements
- R1: While reset is asserted and after it is released, the outputs read as follows: reference ratio 3, all four option bits 0, swallow count 0, main count 3, and the error flag 0.
- R2: Each rising serial-clock edge, seen while the load strobe is low, shifts the data bit into bit 0 of the 19-bit shift register. Earlier bits move toward bit 18. Bits therefore go out MSB first, and the last bit sent lands in bit 0.
- R3: A load with bit 0 = 1 updates the reference register. The field layout is: ratio = bits 14..1, modulus select = bit 15, comparator polarity = bit 16, monitor select = bit 17, pump current select = bit 18.
- R4: A load with bit 0 = 0 updates the divider register. The field layout is: swallow count = bits 7..1, main count = bits 18..8. Any swallow value 0..127 is accepted.
- R5: A load happens only on a rising edge of the load strobe. Shifting a complete word with the strobe low changes no output.
- R6: Serial-clock edges while the load strobe is high do not alter the shift register. A second load strobe afterwards reloads the same word.
- R7: A reference word whose ratio is 0, 1 or 2 leaves the whole reference register (ratio and options) unchanged and sets the error flag.
- R8: A divider word whose main count is 0, 1 or 2 leaves the whole divider register unchanged and sets the error flag.
- R9: The error flag stays set through later valid loads. Only reset clears it.
- R10: A load to one register never changes the other register.
- R11: If more than 19 bits are sent before a load, only the last 19 are used. The boundary values 3, 16383 (ratio) and 2047 (main count) are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial bit clock, asynchronous |
| serData | input | 1 | Serial data bit, asynchronous |
| serLoad | input | 1 | Load strobe, asynchronous; rising edge commits the word |
| refRatio | output | 14 | Reference divide ratio |
| modSel | output | 1 | Prescaler modulus select option |
| cmpPolarity | output | 1 | Phase comparator polarity option |
| monSel | output | 1 | Monitor output select option |
| pumpHi | output | 1 | Charge-pump current select option |
| swallowCnt | output | 7 | Swallow count |
| mainCnt | output | 11 | Main programmable count |
| cfgErr | output | 1 | Sticky flag: a word with an illegal ratio was refused |

## Verification
The reference path is swept over ratios 3 to 34, with the option bits cycling through all sixteen combinations. Alternating-bit and all-ones ratios follow, which expose swapped or shifted field boundaries. The divider path is swept over every swallow value, each paired with a different main count, so that any overlap between the two fields shows up.

The illegal values 0, 1 and 2 are loaded to each register with non-zero neighbouring fields, which separates a full rejection from a partial write. Over-long words, full words sent without a load, and clock pulses during a held strobe each show whether the shift register and the load edge detector honour the strobe level.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  // Strobes from the control section to the datapath
  typedef struct packed {
    logic shiftEn;   // one system cycle per serial rising edge
    logic shiftBit;  // synchronized data bit to shift in
    logic loadEn;    // one system cycle per load-strobe rising edge
    logic leHigh;    // synchronized load-strobe level
  } cfg_strobe_t;

  // Reference word option bits, MSB first as they sit in the word
  typedef struct packed {
    logic pumpHi;
    logic monSel;
    logic cmpPolarity;
    logic modSel;
  } ref_opts_t;

  localparam int OPT_W = $bits(ref_opts_t);

endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] stage;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= '0;
        else       stage <= asyncIn;
      end
      assign syncOut = stage;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn};
      end
      assign syncOut = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serLoad,
  output cfg_strobe_t strb
);

  localparam int N_IN = 3;

  logic [N_IN-1:0] rawIn;
  logic [N_IN-1:0] syncIn;
  logic            clkS;
  logic            dataS;
  logic            leS;
  logic            clkPrev;
  logic            lePrev;

  assign rawIn = {serLoad, serClk, serData};

  synth_cfg_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (N_IN)
  ) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (rawIn),
    .syncOut (syncIn)
  );

  assign {leS, clkS, dataS} = syncIn;

  // Previous synchronized levels for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      lePrev  <= 1'b0;
    end else begin
      clkPrev <= clkS;
      lePrev  <= leS;
    end
  end

  always_comb begin
    strb.shiftEn  = clkS & ~clkPrev & ~leS;
    strb.shiftBit = dataS;
    strb.loadEn   = leS & ~lePrev;
    strb.leHigh   = leS;
  end

endmodule

// File: rtl/synth_cfg_dp.sv
module synth_cfg_dp
  import synth_cfg_pkg::*;
#(
  parameter int REF_W     = 14,
  parameter int SWAL_W    = 7,
  parameter int MAIN_W    = 11,
  parameter int MIN_RATIO = 3,
  parameter int WORD_W    = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_strobe_t       strb,
  output logic [WORD_W-1:0] shiftWord,
  output logic [REF_W-1:0]  refRatio,
  output ref_opts_t         refOpts,
  output logic [SWAL_W-1:0] swallowCnt,
  output logic [MAIN_W-1:0] mainCnt,
  output logic              cfgErr
);

  // Field positions inside the word; bit 0 is the routing flag
  localparam int REF_LO  = 1;
  localparam int REF_HI  = REF_W;
  localparam int OPT_LO  = REF_W + 1;
  localparam int OPT_HI  = REF_W + OPT_W;
  localparam int SW_LO   = 1;
  localparam int SW_HI   = SWAL_W;
  localparam int MAIN_LO = SWAL_W + 1;
  localparam int MAIN_HI = SWAL_W + MAIN_W;

  localparam logic [REF_W-1:0]  REF_MIN  = REF_W'(MIN_RATIO);
  localparam logic [MAIN_W-1:0] MAIN_MIN = MAIN_W'(MIN_RATIO);

  logic              routeRef;
  logic [REF_W-1:0]  refField;
  ref_opts_t         optField;
  logic [SWAL_W-1:0] swField;
  logic [MAIN_W-1:0] mainField;
  logic              refOk;
  logic              mainOk;
  logic              refWr;
  logic              divWr;
  logic              reject;

  always_comb begin
    routeRef  = shiftWord[0];
    refField  = shiftWord[REF_HI:REF_LO];
    optField  = ref_opts_t'(shiftWord[OPT_HI:OPT_LO]);
    swField   = shiftWord[SW_HI:SW_LO];
    mainField = shiftWord[MAIN_HI:MAIN_LO];
    refOk     = refField >= REF_MIN;
    mainOk    = mainField >= MAIN_MIN;
    refWr     = strb.loadEn &  routeRef & refOk;
    divWr     = strb.loadEn & ~routeRef & mainOk;
    reject    = strb.loadEn & ((routeRef & ~refOk) | (~routeRef & ~mainOk));
  end

  // Serial shift register, newest bit at position 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      shiftWord <= '0;
    else if (strb.shiftEn && !strb.leHigh)
      shiftWord <= {shiftWord[WORD_W-2:0], strb.shiftBit};
  end

  // Reference holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refRatio <= REF_MIN;
      refOpts  <= '0;
    end else if (refWr) begin
      refRatio <= refField;
      refOpts  <= optField;
    end
  end

  // Divider holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swallowCnt <= '0;
      mainCnt    <= MAIN_MIN;
    end else if (divWr) begin
      swallowCnt <= swField;
      mainCnt    <= mainField;
    end
  end

  // Sticky rejection flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       cfgErr <= 1'b0;
    else if (reject) cfgErr <= 1'b1;
  end

endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
  import synth_cfg_pkg::*;
#(
  parameter int REF_W       = 14,
  parameter int SWAL_W      = 7,
  parameter int MAIN_W      = 11,
  parameter int MIN_RATIO   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLoad,
  output logic [REF_W-1:0]  refRatio,
  output logic              modSel,
  output logic              cmpPolarity,
  output logic              monSel,
  output logic              pumpHi,
  output logic [SWAL_W-1:0] swallowCnt,
  output logic [MAIN_W-1:0] mainCnt,
  output logic              cfgErr
);

  localparam int REF_BODY = REF_W + OPT_W;
  localparam int DIV_BODY = SWAL_W + MAIN_W;
  localparam int WORD_W   = 1 + ((REF_BODY > DIV_BODY) ? REF_BODY : DIV_BODY);

  cfg_strobe_t       strb;
  logic [WORD_W-1:0] shiftWord;
  ref_opts_t         refOpts;

  synth_cfg_ctrl #(
    .SYNC_STAGES (SYNC_STAGES)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .serClk  (serClk),
    .serData (serData),
    .serLoad (serLoad),
    .strb    (strb)
  );

  synth_cfg_dp #(
    .REF_W     (REF_W),
    .SWAL_W    (SWAL_W),
    .MAIN_W    (MAIN_W),
    .MIN_RATIO (MIN_RATIO),
    .WORD_W    (WORD_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .shiftWord  (shiftWord),
    .refRatio   (refRatio),
    .refOpts    (refOpts),
    .swallowCnt (swallowCnt),
    .mainCnt    (mainCnt),
    .cfgErr     (cfgErr)
  );

  assign {pumpHi, monSel, cmpPolarity, modSel} = refOpts;

endmodule

// File: rtl/synth_cfg_chk.sv
module synth_cfg_chk
  import synth_cfg_pkg::*;
#(
  parameter int REF_W     = 14,
  parameter int MAIN_W    = 11,
  parameter int MIN_RATIO = 3,
  parameter int WORD_W    = 19
) (
  input logic              clk,
  input logic              rstN,
  input cfg_strobe_t       strb,
  input logic [WORD_W-1:0] shiftWord,
  input logic [REF_W-1:0]  refRatio,
  input logic [MAIN_W-1:0] mainCnt,
  input logic              cfgErr
);

  localparam logic [REF_W-1:0]  REF_MIN  = REF_W'(MIN_RATIO);
  localparam logic [MAIN_W-1:0] MAIN_MIN = MAIN_W'(MIN_RATIO);

  // R5
  load_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn |=> !strb.loadEn);

  // R6
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.leHigh |=> $stable(shiftWord));

  // R7
  ref_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    refRatio >= REF_MIN);

  // R8
  main_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    mainCnt >= MAIN_MIN);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);

  // R10
  ref_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(refRatio) |-> $past(strb.loadEn && shiftWord[0]));

  // R10
  div_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mainCnt) |-> $past(strb.loadEn && !shiftWord[0]));

endmodule

bind synth_cfg_port synth_cfg_chk #(
  .REF_W     (REF_W),
  .MAIN_W    (MAIN_W),
  .MIN_RATIO (MIN_RATIO),
  .WORD_W    (WORD_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .strb      (strb),
  .shiftWord (shiftWord),
  .refRatio  (refRatio),
  .mainCnt   (mainCnt),
  .cfgErr    (cfgErr)
);

// File: tb/synth_cfg_port_tb.sv
`timescale 1ns/1ps
module synth_cfg_port_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b0;
  logic        serData = 1'b0;
  logic        serLoad = 1'b0;
  logic [13:0] refRatio;
  logic        modSel, cmpPolarity, monSel, pumpHi;
  logic [6:0]  swallowCnt;
  logic [10:0] mainCnt;
  logic        cfgErr;

  int nChecks = 0;
  int nFail   = 0;

  // Bench model
  logic [13:0] expRatio = 14'd3;
  logic [3:0]  expOpt   = 4'd0;   // {pump, monitor, polarity, modulus}
  logic [6:0]  expSw    = 7'd0;
  logic [10:0] expMain  = 11'd3;
  logic        expErr   = 1'b0;

  always #2.5 clk = ~clk;

  synth_cfg_port dut_i (
    .clk (clk), .rstN (rstN), .serClk (serClk), .serData (serData),
    .serLoad (serLoad), .refRatio (refRatio), .modSel (modSel),
    .cmpPolarity (cmpPolarity), .monSel (monSel), .pumpHi (pumpHi),
    .swallowCnt (swallowCnt), .mainCnt (mainCnt), .cfgErr (cfgErr)
  );

  function automatic logic [18:0] mkRef(input logic [13:0] r, input logic [3:0] o);
    return {o, r, 1'b1};
  endfunction

  function automatic logic [18:0] mkDiv(input logic [10:0] m, input logic [6:0] s);
    return {m, s, 1'b0};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    chk(req, "refRatio", int'(refRatio), int'(expRatio));
    chk(req, "options", int'({pumpHi, monSel, cmpPolarity, modSel}), int'(expOpt));
    chk(req, "swallowCnt", int'(swallowCnt), int'(expSw));
    chk(req, "mainCnt", int'(mainCnt), int'(expMain));
    chk(req, "cfgErr", int'(cfgErr), int'(expErr));
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk) serData = b;
    repeat (4) @(negedge clk);
    serClk = 1'b1;
    repeat (4) @(negedge clk);
    serClk = 1'b0;
  endtask

  task automatic sendWord(input logic [18:0] w);
    for (int i = 18; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic pulseLoad();
    @(negedge clk) serLoad = 1'b1;
    repeat (6) @(negedge clk);
    serLoad = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic model(input logic [18:0] w);
    if (w[0]) begin
      if (w[14:1] >= 14'd3) begin expRatio = w[14:1]; expOpt = w[18:15]; end
      else expErr = 1'b1;
    end else begin
      if (w[18:8] >= 11'd3) begin expMain = w[18:8]; expSw = w[7:1]; end
      else expErr = 1'b1;
    end
  endtask

  task automatic loadWord(input logic [18:0] w, input string req);
    sendWord(w);
    pulseLoad();
    model(w);
    checkAll(req);
  endtask

  task automatic resetModel();
    expRatio = 14'd3; expOpt = 4'd0; expSw = 7'd0; expMain = 11'd3; expErr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R1");               // R1 during reset
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkAll("R1");               // R1 after release

    // R2 R3 R10: reference sweep, all option combinations
    for (int r = 3; r <= 34; r++) loadWord(mkRef(14'(r), 4'(r)), "R3");
    loadWord(mkRef(14'h2AAA, 4'b0101), "R2");
    loadWord(mkRef(14'h1555, 4'b1010), "R2");
    loadWord(mkRef(14'd16383, 4'b1111), "R11");
    loadWord(mkRef(14'd3, 4'b0000), "R11");

    // R4 R10: divider sweep, every swallow value
    for (int s = 0; s < 128; s++) loadWord(mkDiv(11'(2047 - s * 13), 7'(s)), "R4");
    loadWord(mkDiv(11'd2047, 7'd127), "R11");
    loadWord(mkDiv(11'd3, 7'd0), "R11");
    loadWord(mkDiv(11'h555, 7'h2A), "R2");

    // R5: full word without load edge changes nothing
    sendWord(mkRef(14'd999, 4'b1001));
    repeat (6) @(negedge clk);
    checkAll("R5");
    pulseLoad();
    model(mkRef(14'd999, 4'b1001));
    checkAll("R5");

    // R6: clock pulses while strobe is held high are ignored
    sendWord(mkDiv(11'd700, 7'd33));
    @(negedge clk) serLoad = 1'b1;
    repeat (6) @(negedge clk);
    for (int k = 0; k < 7; k++) sendBit(1'b1);
    @(negedge clk) serLoad = 1'b0;
    repeat (6) @(negedge clk);
    pulseLoad();
    model(mkDiv(11'd700, 7'd33));
    checkAll("R6");

    // R11: extra leading bits are discarded
    for (int k = 0; k < 5; k++) sendBit(1'b1);
    loadWord(mkDiv(11'd1234, 7'd5), "R11");

    // R7: illegal reference ratios
    for (int r = 0; r < 3; r++) loadWord(mkRef(14'(r), 4'b1111), "R7");
    // R8: illegal main counts
    for (int m = 0; m < 3; m++) loadWord(mkDiv(11'(m), 7'd99), "R8");

    // R9: flag survives valid loads
    loadWord(mkRef(14'd500, 4'b0011), "R9");
    loadWord(mkDiv(11'd900, 7'd12), "R9");

    // R1 R9: reset clears the flag and restores defaults
    @(negedge clk) rstN = 1'b0;
    repeat (3) @(negedge clk);
    resetModel();
    checkAll("R1");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkAll("R9");
    loadWord(mkDiv(11'd2, 7'd1), "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule